// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives a card clock from a fast tick clock and divides it down by 1, 2, 4 or 8. The ratio is chosen by a two-bit select whose code steps through the ratios one bit at a time. The tick clock `clk_i` runs at twice the reference rate, so every high and low phase of the card clock is a whole number of ticks. That makes divide-by-1 a plain registered output with an exact 50% duty cycle, not a gated copy of the clock.

Ratio changes and gate changes are never applied as they arrive. A free-running phase counter wraps every 16 ticks (eight reference periods). At that moment every ratio is at the end of a high phase and about to start a low phase. The select is first synchronized into the tick domain. The new ratio and the new gate state are loaded only on a wrap, so the pulse before a change and the pulse after it both keep their full widths. The sequencer drives `gate_i` in the same clock domain. While the clock is disabled the output is held low.

Top module: `card_clk_div`

## Requirements
- R1: The select pair (`sel_a_i`, `sel_b_i`) picks the ratio: 00 gives /8, 01 gives /4, 11 gives /2, 10 gives /1. A divide of /N makes each output high and low phase last N ticks of `clk_i`.
- R2: In steady running, each high phase equals the low phase that follows it, so the duty cycle is 50% at every ratio.
- R3: A ratio change is applied only at the counter wrap, where every ratio starts a low phase. No high phase ever has a length outside {1, 2, 4, 8} ticks, and no low phase of 8 ticks or less has any other length.
- R4: Once a select change has been stable for SYNC_STAGES + 18 ticks, every later rising edge starts a high phase of the new ratio.
- R5: While the gate is low, the output stays low once the next wrap has passed.
- R6: When the gate rises, the first high phase at the output has the full width of the selected ratio.
- R7: During reset, and after reset until a wrap sees the gate high, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock at twice the reference rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Clock enable from the sequencer, synchronous to clk_i |
| sel_a_i | input | 1 | First ratio select bit, asynchronous |
| sel_b_i | input | 1 | Second ratio select bit, asynchronous |
| card_clk_o | output | 1 | Divided card clock, registered |

## Verification
The bench builds the block with its default two-stage select synchronizer. With the fixed four-bit phase counter, a change can wait at most 16 ticks for a boundary. The whole latency window is therefore about 20 ticks, which lets the bench measure each ratio exactly at the R4 bound rather than after a generous settle time. The select walk follows the single-bit Gray order in both directions, so it covers every neighbouring pair of ratios, including the jump between /2 and /1. A monitor checks the length of every completed phase throughout the run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_LOG = 3;
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int EXP_W   = $clog2(MAX_LOG + 1);

  typedef logic [EXP_W-1:0] exp_t;

  // Gray-ordered select: adjacent codes are adjacent ratios
  function automatic exp_t sel_to_exp(input logic [1:0] sel);
    case (sel)
      2'b00:   return exp_t'(3);
      2'b01:   return exp_t'(2);
      2'b11:   return exp_t'(1);
      default: return exp_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdiv_phase_cnt.sv
module cdiv_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/cdiv_ratio_ctrl.sv
module cdiv_ratio_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  input  logic [1:0] sel_i,
  input  logic       gate_i,
  output exp_t       exp_o,
  output logic       run_o
);
  exp_t exp_q;
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= exp_t'(MAX_LOG);
      run_q <= 1'b0;
    end else if (wrap_i) begin
      exp_q <= sel_to_exp(sel_i);
      run_q <= gate_i;
    end
  end

  assign exp_o = exp_q;
  assign run_o = run_q;

  // R3: ratio only moves at the common boundary
  a_r3_switch_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(exp_q));

  // R6: gate state only moves at the common boundary
  a_r6_gate_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(run_q));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  output logic card_clk_o
);
  logic [1:0]       sel_sync;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  exp_t             exp_cur;
  logic             run;
  logic             out_q;

  cdiv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_a_i, sel_b_i}),
    .q_o    (sel_sync)
  );

  cdiv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  cdiv_ratio_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .sel_i  (sel_sync),
    .gate_i (gate_i),
    .exp_o  (exp_cur),
    .run_o  (run)
  );

  // Counter bit k toggles every 2^k ticks: half-period of ratio /2^k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else out_q <= run & cnt[exp_cur];
  end

  assign card_clk_o = out_q;

  // R3: every ratio enters a low phase right after the boundary
  a_r3_low_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> ##2 !card_clk_o);

  // R5: a stopped clock leaves the output low
  a_r5_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !card_clk_o);
endmodule

// File: tb/card_clk_div_test.sv
`timescale 1ns/1ps
module card_clk_div_test;
  localparam int SYNC    = 2;
  localparam int LAT     = SYNC + 18;
  localparam int NVEC    = 7;
  localparam int WD_MAX  = 150000;

  // {sel_a, sel_b, expected half-period in ticks}
  localparam logic [5:0] VEC [NVEC] = '{
    {2'b00, 4'd8}, {2'b01, 4'd4}, {2'b11, 4'd2}, {2'b10, 4'd1},
    {2'b11, 4'd2}, {2'b01, 4'd4}, {2'b00, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b0;
  logic sel_a = 1'b0;
  logic sel_b = 1'b0;
  logic card_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  card_clk_div #(.SYNC_STAGES(SYNC)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gate_i     (gate),
    .sel_a_i    (sel_a),
    .sel_b_i    (sel_b),
    .card_clk_o (card_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    logic p;
    p = card_clk;
    @(negedge clk);
    while (!(p == 1'b0 && card_clk == 1'b1)) begin
      p = card_clk;
      @(negedge clk);
    end
    hi = 0;
    while (card_clk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!card_clk) begin lo++; @(negedge clk); end
  endtask

  // R3 monitor: length of every completed phase
  logic mon_prev = 1'b0;
  int   mon_len = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (card_clk != mon_prev) begin
        if (mon_prev) begin
          checks++;
          if (!(mon_len == 1 || mon_len == 2 || mon_len == 4 || mon_len == 8)) begin
            errors++;
            $display("FAIL R3: high phase actual %0d expected one of 1,2,4,8", mon_len);
          end
        end else if (mon_len <= 8) begin
          checks++;
          if (!(mon_len == 1 || mon_len == 2 || mon_len == 4 || mon_len == 8)) begin
            errors++;
            $display("FAIL R3: low phase actual %0d expected one of 1,2,4,8", mon_len);
          end
        end
        mon_len = 1;
      end else mon_len++;
      mon_prev = card_clk;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_MAX && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WD_MAX);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, lowcnt;
    // R7: output low in reset
    ticks(5);
    check("R7 in reset", int'(card_clk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    lowcnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (card_clk) lowcnt++;
    end
    check("R7 after reset, gate low", lowcnt, 0);

    // R1/R2/R4: Gray walk of the select, measured at the latency bound
    gate = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      sel_a = VEC[v][5];
      sel_b = VEC[v][4];
      ticks(LAT);
      measure(hi, lo);
      check("R1/R4 high width", hi, int'(VEC[v][3:0]));
      check("R2 low width", lo, int'(VEC[v][3:0]));
    end

    // R5: gate low holds output low
    gate = 1'b0;
    ticks(20);
    lowcnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (card_clk) lowcnt++;
    end
    check("R5 gated high samples", lowcnt, 0);

    // R6: restart at /4 gives a full first pulse
    sel_a = 1'b0;
    sel_b = 1'b1;
    ticks(LAT);
    gate = 1'b1;
    measure(hi, lo);
    check("R6 first high width /4", hi, 4);

    // R6: restart at /1
    gate = 1'b0;
    sel_a = 1'b1;
    sel_b = 1'b1;
    ticks(LAT);
    sel_b = 1'b0;
    ticks(LAT);
    gate = 1'b1;
    measure(hi, lo);
    check("R6 first high width /1", hi, 1);
    check("R2 low width /1", lo, 1);

    // R7: reset mid-run drops the output
    ticks(3);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset while running", int'(card_clk), 0);
    rst_n = 1'b1;
    ticks(5);
    check("R7 low before first boundary", int'(card_clk), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule